// File: doc/BRIEF.md
# Table-Driven Capture Trigger

This block decides, one sample at a time, when a 16-channel logic capture should trigger. The channels are split into four quads of four channels. Each quad's four current levels index a 16-bit truth table, so any function of those four channels can be programmed, not only an equal-to-value compare. One set of four quad tables forms the level condition. Two further sets form the conditions of two edge units. Each edge unit is normally bound to a single channel. The present and previous results of the two units index a 16-bit combining table, which can express rise, fall, OR, AND, XOR and their negations.

The tables are filled by a simple write port. Sixteen row writes each carry one bit position of all twelve quad tables, and one further write loads the combining table. Software arms the block with a one-cycle `arm_i` pulse. The first valid sample after arming whose level condition and combining-table bit are both true produces a one-cycle `trig_o` pulse. It also sets `trig_seen_o`, which stays high until the next arm.

Top module: `lut_trigger`

## Requirements
- R1: After reset `trig_o` and `trig_seen_o` are 0. The level tables hold all ones, the edge-unit tables hold zeros and the combining table holds zero, so no trigger occurs until the combining table is loaded.
- R2: A write with `cfg_addr_i[7:4]` = 4'h3 loads bit position `cfg_addr_i[3:0]` of every quad table. Data bits [3:0] go to level quads 0..3, bits [7:4] to edge-unit 0 quads 0..3, and bits [11:8] to edge-unit 1 quads 0..3. A write to address 8'h40 loads the combining table from `cfg_wdata_i[15:0]`.
- R3: Quad q covers channels 4q..4q+3, and channel 4q is the least significant bit of the table index. The level condition is the AND over the four quads of the indexed table bit.
- R4: Each edge unit's result is the AND of its four indexed quad bits. The combining-table index is {unit1 current, unit1 previous, unit0 current, unit0 previous}, with unit0 previous in bit 0.
- R5: A trigger needs both the level condition and the indexed combining-table bit to be 1.
- R6: `trig_o` goes high for exactly one cycle, in the cycle after the qualifying sample is presented.
- R7: Only the first qualifying sample after an arm produces a pulse. `trig_seen_o` stays 1 until the next arm.
- R8: `arm_i` clears `trig_seen_o` at the next edge. The first valid sample after an arm serves as its own previous sample, so it cannot produce an edge.
- R9: A sample with `smp_vld_i` = 0 can neither trigger nor update the edge history.
- R10: Before the first arm after reset, no sample triggers.
- R11: A write to any address other than the row range and 8'h40 changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm pulse; clears the sticky status and the edge history |
| smp_i | input | 16 | Channel levels of the current sample |
| smp_vld_i | input | 1 | Current sample is valid |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | 8 | Table write address (row or combining table) |
| cfg_wdata_i | input | 16 | Table write data |
| trig_o | output | 1 | One-cycle trigger pulse |
| trig_seen_o | output | 1 | Sticky triggered status |

## Verification
A sample presented before a clock edge yields its `trig_o` decision right after that edge, and the pulse lasts until the following edge. Table writes and `arm_i` likewise take effect at the next edge. The bench drives each input on a falling edge and reads the outputs on the next falling edge, which is exactly one rising edge later. Every expected pulse and every expected non-pulse is therefore attributed to a single sample. The edge cases rely on sample ordering, so each scenario task spells out its sequence one cycle at a time.

// File: rtl/lut_trig_pkg.sv
package lut_trig_pkg;
  // Defaults shared by the trigger modules
  localparam int DEF_QUADS  = 4;
  localparam int DEF_QUAD_W = 4;
  localparam int DEF_UNITS  = 2;
  localparam int DEF_CFG_AW = 8;
  localparam int DEF_CFG_DW = 16;
  // Upper address nibble selecting a row write, and the combining-table address
  localparam int ROW_TAG    = 3;
  localparam int GLUE_ADDR  = 64;
endpackage

// File: rtl/lut_trig_cfg.sv
module lut_trig_cfg
  import lut_trig_pkg::*;
#(
  parameter int NUM_QUADS = DEF_QUADS,
  parameter int QUAD_W    = DEF_QUAD_W,
  parameter int NUM_UNITS = DEF_UNITS,
  parameter int CFG_AW    = DEF_CFG_AW,
  parameter int CFG_DW    = DEF_CFG_DW
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_we,
  input  logic [CFG_AW-1:0]                             cfg_addr,
  input  logic [CFG_DW-1:0]                             cfg_wdata,
  output logic [NUM_QUADS-1:0][(1<<QUAD_W)-1:0]         val_tbl,
  output logic [NUM_UNITS-1:0][NUM_QUADS-1:0][(1<<QUAD_W)-1:0] unit_tbl,
  output logic [(1<<(2*NUM_UNITS))-1:0]                 glue_tbl
);
  localparam int LUT_D  = 1 << QUAD_W;
  localparam int GLUE_D = 1 << (2*NUM_UNITS);
  localparam int TAG_W  = CFG_AW - QUAD_W;

  logic             row_wr;
  logic             glue_wr;
  logic [QUAD_W-1:0] row;

  assign row     = cfg_addr[QUAD_W-1:0];
  assign row_wr  = cfg_we && (cfg_addr[CFG_AW-1:QUAD_W] == TAG_W'(ROW_TAG));
  assign glue_wr = cfg_we && (cfg_addr == CFG_AW'(GLUE_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_tbl  <= '1;
      unit_tbl <= '0;
      glue_tbl <= '0;
    end else begin
      if (row_wr) begin
        for (int q = 0; q < NUM_QUADS; q++) begin
          val_tbl[q][row] <= cfg_wdata[q];
          for (int u = 0; u < NUM_UNITS; u++)
            unit_tbl[u][q][row] <= cfg_wdata[(u+1)*NUM_QUADS + q];
        end
      end
      if (glue_wr)
        glue_tbl <= cfg_wdata[GLUE_D-1:0];
    end
  end

  // R2
  glue_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glue_wr |=> glue_tbl == $past(cfg_wdata[GLUE_D-1:0]));
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_wr && !glue_wr) |=> ($stable(val_tbl) && $stable(unit_tbl) && $stable(glue_tbl)));
  // R2
  row_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_wr |=> val_tbl[0][$past(row)] == $past(cfg_wdata[0]));
endmodule

// File: rtl/lut_trig_match.sv
module lut_trig_match
  import lut_trig_pkg::*;
#(
  parameter int NUM_QUADS = DEF_QUADS,
  parameter int QUAD_W    = DEF_QUAD_W
) (
  input  logic [NUM_QUADS-1:0][(1<<QUAD_W)-1:0] tbl,
  input  logic [NUM_QUADS*QUAD_W-1:0]           smp,
  output logic                                  hit
);
  logic [NUM_QUADS-1:0] quad_hit;

  // R3: each quad looks up its own nibble, channel 4q is the index LSB
  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    assign quad_hit[q] = tbl[q][smp[q*QUAD_W +: QUAD_W]];
  end

  assign hit = &quad_hit;
endmodule

// File: rtl/lut_trig_ctl.sv
module lut_trig_ctl
  import lut_trig_pkg::*;
#(
  parameter int NUM_UNITS = DEF_UNITS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             arm,
  input  logic                             smp_vld,
  input  logic                             val_hit,
  input  logic [NUM_UNITS-1:0]             unit_cur,
  input  logic [(1<<(2*NUM_UNITS))-1:0]    glue_tbl,
  output logic                             trig,
  output logic                             seen
);
  localparam int GI_W = 2*NUM_UNITS;

  // R4: bit 2u is unit u previous, bit 2u+1 is unit u current
  function automatic logic [GI_W-1:0] glue_index(input logic [NUM_UNITS-1:0] prv,
                                                 input logic [NUM_UNITS-1:0] cur);
    logic [GI_W-1:0] idx;
    for (int u = 0; u < NUM_UNITS; u++) begin
      idx[2*u]   = prv[u];
      idx[2*u+1] = cur[u];
    end
    return idx;
  endfunction

  logic                 armed;
  logic                 first;
  logic [NUM_UNITS-1:0] unit_prev;
  logic [NUM_UNITS-1:0] prev_eff;
  logic [GI_W-1:0]      gidx;
  logic                 edge_hit;
  logic                 fire;

  // R8: first sample after arm stands in for its own predecessor
  assign prev_eff = first ? unit_cur : unit_prev;
  assign gidx     = glue_index(prev_eff, unit_cur);
  assign edge_hit = glue_tbl[gidx];
  // R5, R7, R9, R10
  assign fire     = armed && !seen && smp_vld && val_hit && edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      first     <= 1'b1;
      unit_prev <= '0;
      trig      <= 1'b0;
      seen      <= 1'b0;
    end else if (arm) begin
      armed <= 1'b1;
      first <= 1'b1;
      trig  <= 1'b0;
      seen  <= 1'b0;
    end else begin
      trig <= fire;
      if (fire)
        seen <= 1'b1;
      if (smp_vld && armed) begin
        first     <= 1'b0;
        unit_prev <= unit_cur;
      end
    end
  end

  // R5
  cond_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(val_hit) && $past(edge_hit)));
  // R6
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R7
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !arm) |=> (seen && !trig));
  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!seen && !trig));
  // R9
  vld_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !trig);
  // R10
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !trig);
endmodule

// File: rtl/lut_trigger.sv
module lut_trigger
  import lut_trig_pkg::*;
#(
  parameter int NUM_QUADS = DEF_QUADS,
  parameter int QUAD_W    = DEF_QUAD_W,
  parameter int NUM_UNITS = DEF_UNITS,
  parameter int CFG_AW    = DEF_CFG_AW,
  parameter int CFG_DW    = DEF_CFG_DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm_i,
  input  logic [NUM_QUADS*QUAD_W-1:0] smp_i,
  input  logic                        smp_vld_i,
  input  logic                        cfg_we_i,
  input  logic [CFG_AW-1:0]           cfg_addr_i,
  input  logic [CFG_DW-1:0]           cfg_wdata_i,
  output logic                        trig_o,
  output logic                        trig_seen_o
);
  localparam int LUT_D  = 1 << QUAD_W;
  localparam int GLUE_D = 1 << (2*NUM_UNITS);

  logic [NUM_QUADS-1:0][LUT_D-1:0]                val_tbl;
  logic [NUM_UNITS-1:0][NUM_QUADS-1:0][LUT_D-1:0] unit_tbl;
  logic [GLUE_D-1:0]                              glue_tbl;
  logic                                           val_hit;
  logic [NUM_UNITS-1:0]                           unit_cur;

  lut_trig_cfg #(
    .NUM_QUADS(NUM_QUADS), .QUAD_W(QUAD_W), .NUM_UNITS(NUM_UNITS),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_i), .cfg_addr(cfg_addr_i),
    .cfg_wdata(cfg_wdata_i), .val_tbl(val_tbl), .unit_tbl(unit_tbl),
    .glue_tbl(glue_tbl)
  );

  lut_trig_match #(.NUM_QUADS(NUM_QUADS), .QUAD_W(QUAD_W)) u_val (
    .tbl(val_tbl), .smp(smp_i), .hit(val_hit)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    lut_trig_match #(.NUM_QUADS(NUM_QUADS), .QUAD_W(QUAD_W)) u_edge (
      .tbl(unit_tbl[u]), .smp(smp_i), .hit(unit_cur[u])
    );
  end

  lut_trig_ctl #(.NUM_UNITS(NUM_UNITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .arm(arm_i), .smp_vld(smp_vld_i),
    .val_hit(val_hit), .unit_cur(unit_cur), .glue_tbl(glue_tbl),
    .trig(trig_o), .seen(trig_seen_o)
  );
endmodule

// File: tb/tb_lut_trigger.sv
`timescale 1ns/1ps
module tb_lut_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        trig_o;
  logic        trig_seen_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [15:0] m_val [4];
  logic [15:0] m_u0  [4];
  logic [15:0] m_u1  [4];
  logic [15:0] m_glue;

  always #2.5 clk = ~clk;

  lut_trigger dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .trig_o(trig_o), .trig_seen_o(trig_seen_o)
  );

  // Truth table for one quad: a bit is set when every masked level agrees
  function automatic logic [15:0] quad_tbl(input logic [3:0] want, input logic [3:0] msk);
    logic [15:0] t;
    for (int j = 0; j < 16; j++)
      t[j] = (((4'(j) ^ want) & msk) == 4'h0);
    return t;
  endfunction

  function automatic logic [15:0] glue_of(input bit rise0, input bit fall1);
    logic [15:0] g;
    for (int i = 0; i < 16; i++)
      g[i] = (rise0 && (i % 4 == 2)) || (fall1 && ((i / 4) % 4 == 1));
    return g;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic set_level(input logic [15:0] v, input logic [15:0] m);
    for (int q = 0; q < 4; q++) m_val[q] = quad_tbl(v[4*q +: 4], m[4*q +: 4]);
  endtask

  task automatic set_unit(input int u, input int ch);
    logic [15:0] b;
    b = 16'(1) << ch;
    for (int q = 0; q < 4; q++) begin
      if (u == 0) m_u0[q] = quad_tbl(b[4*q +: 4], b[4*q +: 4]);
      else        m_u1[q] = quad_tbl(b[4*q +: 4], b[4*q +: 4]);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // R2: row j carries bit j of level, unit0 and unit1 tables
  task automatic push_cfg();
    logic [15:0] w;
    for (int j = 0; j < 16; j++) begin
      w = '0;
      for (int q = 0; q < 4; q++) begin
        w[q]     = m_val[q][j];
        w[4 + q] = m_u0[q][j];
        w[8 + q] = m_u1[q][j];
      end
      cfg_write(8'h30 | 8'(j), w);
    end
    cfg_write(8'h40, m_glue);
  endtask

  task automatic do_arm();
    arm_i = 1'b1; smp_vld_i = 1'b0;
    @(negedge clk);
    arm_i = 1'b0;
    chk(trig_seen_o, 1'b0, "R8 seen cleared by arm");
  endtask

  task automatic step(input logic [15:0] s, input logic v, input logic exp, input string tag);
    smp_i = s; smp_vld_i = v;
    @(negedge clk);
    smp_vld_i = 1'b0;
    chk(trig_o, exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(trig_o, 1'b0, "R1 trig low after reset");
    chk(trig_seen_o, 1'b0, "R1 seen low after reset");
    do_arm();
    step(16'hFFFF, 1'b1, 1'b0, "R1 empty glue no trigger");
    step(16'h0000, 1'b1, 1'b0, "R1 empty glue no trigger");
  endtask

  task automatic t_unarmed();
    do_reset();
    set_level(16'h0000, 16'h0000);
    set_unit(0, 3); set_unit(1, 9);
    m_glue = 16'hFFFF;
    push_cfg();
    step(16'h1234, 1'b1, 1'b0, "R10 no trigger before arm");
    step(16'h0000, 1'b1, 1'b0, "R10 no trigger before arm");
  endtask

  task automatic t_level();
    set_level(16'h1234, 16'hFFFF);
    m_glue = 16'hFFFF;
    push_cfg();
    cfg_write(8'h20, 16'h0000);
    cfg_write(8'h50, 16'h0000);
    cfg_write(8'h41, 16'h0000);
    do_arm();
    step(16'h1235, 1'b1, 1'b0, "R3 mismatch quad0");
    step(16'h9234, 1'b1, 1'b0, "R3 mismatch quad3");
    step(16'h1234, 1'b1, 1'b1, "R11 R3 exact match fires");
    chk(trig_seen_o, 1'b1, "R7 seen set");
    step(16'h1234, 1'b1, 1'b0, "R7 second match no pulse");
    chk(trig_seen_o, 1'b1, "R7 seen sticky");
    do_arm();
    set_level(16'h0050, 16'h00F0);
    push_cfg();
    step(16'hAB6C, 1'b1, 1'b0, "R3 masked nibble differs");
    step(16'hAB5C, 1'b1, 1'b1, "R3 masked nibble matches");
    step(16'hAB5C, 1'b1, 1'b0, "R6 pulse lasts one cycle");
  endtask

  task automatic t_rise_first();
    set_level(16'h0000, 16'h0000);
    set_unit(0, 3); set_unit(1, 9);
    m_glue = glue_of(1'b1, 1'b0);
    push_cfg();
    do_arm();
    step(16'h0008, 1'b1, 1'b0, "R8 first sample high no edge");
    step(16'h0008, 1'b1, 1'b0, "R4 steady high no edge");
    step(16'h0000, 1'b1, 1'b0, "R4 fall not selected");
    step(16'h0008, 1'b1, 1'b1, "R4 rise on ch3 fires");
    chk(trig_seen_o, 1'b1, "R7 seen after rise");
  endtask

  task automatic t_or();
    m_glue = glue_of(1'b1, 1'b1);
    push_cfg();
    do_arm();
    step(16'h0200, 1'b1, 1'b0, "R8 first sample");
    step(16'h0200, 1'b1, 1'b0, "R4 steady");
    step(16'h0000, 1'b1, 1'b1, "R4 fall on ch9 via OR");
    do_arm();
    step(16'h0000, 1'b1, 1'b0, "R8 first sample");
    step(16'h0008, 1'b1, 1'b1, "R4 rise on ch3 via OR");
  endtask

  task automatic t_and();
    set_level(16'h0001, 16'h0001);
    m_glue = glue_of(1'b1, 1'b0);
    push_cfg();
    do_arm();
    step(16'h0000, 1'b1, 1'b0, "R8 first sample");
    step(16'h0008, 1'b1, 1'b0, "R5 edge without level");
    step(16'h0001, 1'b1, 1'b0, "R5 level without edge");
    step(16'h0009, 1'b1, 1'b1, "R5 edge and level fire");
  endtask

  task automatic t_valid();
    set_level(16'h0000, 16'h0000);
    push_cfg();
    do_arm();
    step(16'h0000, 1'b1, 1'b0, "R9 first sample");
    step(16'h0008, 1'b0, 1'b0, "R9 invalid edge ignored");
    step(16'h0008, 1'b1, 1'b1, "R9 edge versus last valid");
    do_arm();
    step(16'h0008, 1'b1, 1'b0, "R8 first sample");
    step(16'h0000, 1'b0, 1'b0, "R9 invalid low ignored");
    step(16'h0008, 1'b1, 1'b0, "R9 history kept high");
  endtask

  initial begin
    for (int q = 0; q < 4; q++) begin m_val[q] = '1; m_u0[q] = '0; m_u1[q] = '0; end
    m_glue = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_unarmed();
    t_level();
    t_rise_first();
    t_or();
    t_and();
    t_valid();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule